// File: doc/BRIEF.md
# Timer-Compare Soft-Interrupt Register Unit

This unit holds a small set of privileged control registers for one processor core. It keeps a 64-bit soft-interrupt vector and a free-running 63-bit tick counter. Two tick compare registers watch the counter: one for the supervisor level and one for the hypervisor level. Alongside these sit an interrupt-level register, a state register that carries the interrupt-enable bit, a hypervisor trap-base register and a read-only version word.

Software reaches every register through one port. That port has a 4-bit register select, a write strobe and 64-bit write data. Reads are combinational on the select. Writing a register can change which interrupts are pending or deliverable. A compare match can do the same. In both cases the unit raises a one-cycle request that tells the core to re-evaluate its pending interrupts. Delivering traps and ranking interrupts are left to the core.

Register select codes:
- 0: soft-interrupt, direct access
- 1: soft-interrupt, set alias
- 2: soft-interrupt, clear alias
- 3: supervisor compare
- 4: hypervisor compare
- 5: interrupt level
- 6: state
- 7: trap base
- 8: version
- 9: tick

Top module: `tick_softint_regs`

## Requirements
- R1: After reset the following hold. The tick counter, the soft-interrupt vector, the interrupt level, the state register and the hypervisor match flag are zero. Both compare registers read 0x8000_0000_0000_0000, so both matches start disabled.
- R2: A write to select 0 stores the write data as the new soft-interrupt vector. The new value is visible on `softint_o` and on a read of select 0, 1 or 2 from the next cycle.
- R3: A write to select 1 stores the previous vector ORed with the write data.
- R4: A write to select 2 stores the previous vector ANDed with the inverted write data.
- R5: Every write to select 0, 1 or 2 pulses `reeval_o` high for exactly the next cycle. This holds even when the stored value does not change.
- R6: Bit 63 of each compare register disables its match when set. An armed compare matches only in the cycle in which bits 62:0 equal the tick counter. A value that the counter has already passed does not fire until the counter wraps.
- R7: When an armed supervisor compare matches, soft-interrupt bit 16 is set and `reeval_o` pulses, both in the cycle after the match.
- R8: When an armed hypervisor compare matches, the sticky flag `hyp_match_o` is set and `reeval_o` pulses, both in the cycle after the match. The soft-interrupt vector is left unchanged. Writing select 4 clears the flag.
- R9: The interrupt level is bits 3:0 of select 5. A write whose bits 3:0 are below the current level pulses `reeval_o`. A write of an equal or higher level does not.
- R10: The interrupt-enable bit is bit 1 of the 8-bit state register at select 6. A write that takes this bit from 0 to 1 pulses `reeval_o`. Any other state write does not.
- R11: The trap base at select 7 always stores and reads bits 14:0 as zero.
- R12: Select 8 reads the window count in bits 7:0, the maximum trap level in bits 15:8 and the maximum global level in bits 23:16. The defaults are 8, 6 and 3. The register cannot be written. A write to select 8, 9 or any unused select changes nothing and pulses `wr_err_o` for the next cycle.
- R13: The tick counter increases by one on every clock. Select 9 reads it with bit 63 as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_sel | input | 4 | Register select |
| reg_wr | input | 1 | Write strobe |
| reg_wdata | input | 64 | Write data |
| reg_rdata | output | 64 | Read data for the selected register |
| softint_o | output | 64 | Soft-interrupt vector |
| hyp_match_o | output | 1 | Sticky hypervisor compare match |
| reeval_o | output | 1 | One-cycle interrupt re-evaluation request |
| wr_err_o | output | 1 | One-cycle flag for a write to a read-only or unused select |

## Verification
The assertions check several rules on every cycle: the set and clear alias arithmetic, the request after every soft-interrupt write, the effects of supervisor and hypervisor matches, the request on an enable rising edge, and the counter's step of one. Other behaviour can only be shown by the bench's timed scenarios. These include the exact cycle in which a compare written against a live counter fires, the silence of a disabled compare or of a value already passed, the stickiness and clearing of the hypervisor flag, and the contents of the version word and the trap base.

// File: rtl/tick_softint_regs.sv
module tick_softint_regs #(
  parameter int NWIN    = 8,
  parameter int MAXTL   = 6,
  parameter int MAXGL   = 3,
  parameter int PIL_W   = 4,
  parameter int ST_W    = 8,
  parameter int IE_BIT  = 1,
  parameter int TBA_LOW = 15,
  parameter int SUP_BIT = 16
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [3:0]  reg_sel,
  input  logic        reg_wr,
  input  logic [63:0] reg_wdata,
  output logic [63:0] reg_rdata,
  output logic [63:0] softint_o,
  output logic        hyp_match_o,
  output logic        reeval_o,
  output logic        wr_err_o
);
  localparam logic [3:0] S_SOFT = 4'd0, S_SET = 4'd1, S_CLR = 4'd2, S_CMPS = 4'd3,
                         S_CMPH = 4'd4, S_PIL = 4'd5, S_STATE = 4'd6, S_TBA = 4'd7,
                         S_VER  = 4'd8, S_TICK = 4'd9;
  localparam logic [63:0] TBA_MASK = ~((64'd1 << TBA_LOW) - 64'd1);
  localparam logic [63:0] HIT_BIT  = 64'd1 << SUP_BIT;
  localparam logic [63:0] VER_VAL  = {40'd0, 8'(MAXGL), 8'(MAXTL), 8'(NWIN)};

  logic [62:0]      tick;
  logic [63:0]      softint, cmp_sup, cmp_hyp, tba, sw_next;
  logic [PIL_W-1:0] pil;
  logic [ST_W-1:0]  state;
  logic             hyp_flag, reeval, err;

  wire sup_hit = !cmp_sup[63] && (cmp_sup[62:0] == tick);
  wire hyp_hit = !cmp_hyp[63] && (cmp_hyp[62:0] == tick);

  wire wr_soft  = reg_wr && (reg_sel == S_SOFT || reg_sel == S_SET || reg_sel == S_CLR);
  wire wr_pil   = reg_wr && reg_sel == S_PIL;
  wire wr_state = reg_wr && reg_sel == S_STATE;
  wire wr_bad   = reg_wr && reg_sel >= S_VER;
  wire pil_drop = wr_pil && (reg_wdata[PIL_W-1:0] < pil);
  wire ie_rise  = wr_state && reg_wdata[IE_BIT] && !state[IE_BIT];
  wire [63:0] hit_mask = sup_hit ? HIT_BIT : 64'd0;

  always_comb begin
    case (reg_sel)
      S_SOFT:  sw_next = reg_wdata;
      S_SET:   sw_next = softint | reg_wdata;
      S_CLR:   sw_next = softint & ~reg_wdata;
      default: sw_next = softint;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tick     <= '0;
      softint  <= '0;
      cmp_sup  <= 64'h8000_0000_0000_0000;
      cmp_hyp  <= 64'h8000_0000_0000_0000;
      pil      <= '0;
      state    <= '0;
      tba      <= '0;
      hyp_flag <= 1'b0;
      reeval   <= 1'b0;
      err      <= 1'b0;
    end else begin
      tick    <= tick + 63'd1;
      softint <= (wr_soft ? sw_next : softint) | hit_mask;
      if (reg_wr && reg_sel == S_CMPS) cmp_sup <= reg_wdata;
      if (reg_wr && reg_sel == S_CMPH) cmp_hyp <= reg_wdata;
      if (wr_pil)   pil   <= reg_wdata[PIL_W-1:0];
      if (wr_state) state <= reg_wdata[ST_W-1:0];
      if (reg_wr && reg_sel == S_TBA) tba <= reg_wdata & TBA_MASK;
      if (hyp_hit) hyp_flag <= 1'b1;
      else if (reg_wr && reg_sel == S_CMPH) hyp_flag <= 1'b0;
      reeval <= wr_soft | sup_hit | hyp_hit | pil_drop | ie_rise;
      err    <= wr_bad;
    end
  end

  always_comb begin
    case (reg_sel)
      S_SOFT, S_SET, S_CLR: reg_rdata = softint;
      S_CMPS:  reg_rdata = cmp_sup;
      S_CMPH:  reg_rdata = cmp_hyp;
      S_PIL:   reg_rdata = 64'(pil);
      S_STATE: reg_rdata = 64'(state);
      S_TBA:   reg_rdata = tba & TBA_MASK;
      S_VER:   reg_rdata = VER_VAL;
      S_TICK:  reg_rdata = {1'b0, tick};
      default: reg_rdata = 64'd0;
    endcase
  end

  assign softint_o   = softint;
  assign hyp_match_o = hyp_flag;
  assign reeval_o    = reeval;
  assign wr_err_o    = err;

  a_r3_set_alias: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_sel == S_SET) |=>
      softint_o == ($past(softint_o) | $past(reg_wdata) | ($past(sup_hit) ? HIT_BIT : 64'd0)));
  a_r4_clr_alias: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_sel == S_CLR) |=>
      softint_o == (($past(softint_o) & ~$past(reg_wdata)) | ($past(sup_hit) ? HIT_BIT : 64'd0)));
  a_r5_soft_reeval: assert property (@(posedge clk) disable iff (!rst_n)
    wr_soft |=> reeval_o);
  a_r7_sup_match: assert property (@(posedge clk) disable iff (!rst_n)
    sup_hit |=> (softint_o[SUP_BIT] && reeval_o));
  a_r8_hyp_match: assert property (@(posedge clk) disable iff (!rst_n)
    hyp_hit |=> (hyp_match_o && reeval_o && (softint_o == $past(wr_soft ? sw_next : softint) | $past(hit_mask))));
  a_r10_ie_rise: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_state && reg_wdata[IE_BIT] && !state[IE_BIT]) |=> reeval_o);
  a_r12_ver_err: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_sel == S_VER) |=> wr_err_o);
  a_r13_tick_step: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> tick == $past(tick) + 63'd1);
endmodule

// File: tb/tick_softint_regs_tb.sv
`timescale 1ns/1ps
module tick_softint_regs_tb;
  localparam logic [3:0] S_SOFT = 4'd0, S_SET = 4'd1, S_CLR = 4'd2, S_CMPS = 4'd3,
                         S_CMPH = 4'd4, S_PIL = 4'd5, S_STATE = 4'd6, S_TBA = 4'd7,
                         S_VER  = 4'd8, S_TICK = 4'd9;
  localparam logic [63:0] DIS = 64'h8000_0000_0000_0000;
  localparam int K_RD = 0, K_SI = 1, K_RE = 2, K_HY = 3, K_ER = 4;

  logic clk = 1'b0, rst_n = 1'b0, reg_wr = 1'b0;
  logic [3:0] reg_sel = '0;
  logic [63:0] reg_wdata = '0, reg_rdata, softint_o;
  logic hyp_match_o, reeval_o, wr_err_o;
  int cyc = 0, n_tests = 0, n_fail = 0;
  logic [63:0] t;
  int n0;

  typedef struct { int c; int k; logic [63:0] v; string req; } exp_t;
  exp_t q[$];

  always #4 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  tick_softint_regs u_dut (.clk(clk), .rst_n(rst_n), .reg_sel(reg_sel), .reg_wr(reg_wr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .softint_o(softint_o),
    .hyp_match_o(hyp_match_o), .reeval_o(reeval_o), .wr_err_o(wr_err_o));

  task automatic push(int c, int k, logic [63:0] v, string req);
    exp_t e; int i;
    e.c = c; e.k = k; e.v = v; e.req = req;
    i = 0;
    while (i < q.size() && q[i].c <= c) i++;
    q.insert(i, e);
  endtask

  always @(negedge clk) begin
    while (q.size() > 0 && q[0].c <= cyc) begin
      exp_t e; logic [63:0] a;
      e = q.pop_front();
      case (e.k)
        K_RD: a = reg_rdata;
        K_SI: a = softint_o;
        K_RE: a = 64'(reeval_o);
        K_HY: a = 64'(hyp_match_o);
        default: a = 64'(wr_err_o);
      endcase
      n_tests++;
      if (e.c != cyc || a !== e.v) begin
        n_fail++;
        $display("FAIL %s kind=%0d cyc=%0d: actual %h expected %h", e.req, e.k, cyc, a, e.v);
      end
    end
  end

  task automatic step(); @(posedge clk); #1; reg_wr = 1'b0; endtask
  task automatic idle(int n); repeat (n) step(); endtask
  task automatic wr(logic [3:0] s, logic [63:0] d); step(); reg_sel = s; reg_wr = 1'b1; reg_wdata = d; endtask
  task automatic rd(logic [3:0] s, logic [63:0] v, string req); step(); reg_sel = s; push(cyc, K_RD, v, req); endtask
  task automatic ex(int dc, int k, logic [63:0] v, string req); push(cyc + dc, k, v, req); endtask
  task automatic rd_tick(); step(); reg_sel = S_TICK; #1; t = reg_rdata; n0 = cyc; endtask

  initial begin
    #(200000 * 8);
    n_fail++;
    $display("FAIL watchdog: actual hung expected done");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    idle(3);
    rst_n = 1'b1;
    // R1 reset state
    rd(S_SOFT, 64'd0, "R1"); ex(0, K_HY, 0, "R1"); ex(0, K_RE, 0, "R1");
    rd(S_CMPS, DIS, "R1"); rd(S_CMPH, DIS, "R1");
    rd(S_PIL, 0, "R1"); rd(S_STATE, 0, "R1");
    // R13 tick steps by one
    rd_tick(); rd(S_TICK, t + 64'd1, "R13"); rd(S_TICK, t + 64'd2, "R13");
    // R2 R3 R4 R5 soft-interrupt ports
    wr(S_SOFT, 64'h0F0); ex(1, K_SI, 64'h0F0, "R2"); ex(1, K_RE, 1, "R5");
    wr(S_SET, 64'h300);  ex(1, K_SI, 64'h3F0, "R3"); ex(1, K_RE, 1, "R5");
    wr(S_CLR, 64'h030);  ex(1, K_SI, 64'h3C0, "R4"); ex(1, K_RE, 1, "R5");
    wr(S_SET, 64'h0);    ex(1, K_SI, 64'h3C0, "R3"); ex(1, K_RE, 1, "R5");
    rd(S_CLR, 64'h3C0, "R2"); ex(1, K_RE, 0, "R5");
    wr(S_SOFT, 64'd0); idle(2);
    // R7 supervisor match fires once counter reaches compare
    rd_tick();
    wr(S_CMPS, t + 64'd20);
    push(n0 + 1, K_RE, 0, "R6");
    push(n0 + 20, K_SI, 0, "R7"); push(n0 + 20, K_RE, 0, "R7");
    push(n0 + 21, K_SI, 64'h1_0000, "R7"); push(n0 + 21, K_RE, 1, "R7");
    push(n0 + 22, K_RE, 0, "R7");
    idle(25);
    wr(S_SOFT, 64'd0); idle(2);
    // R6 disabled compare never fires
    rd_tick();
    wr(S_CMPS, DIS | (t + 64'd20));
    push(n0 + 21, K_SI, 0, "R6"); push(n0 + 21, K_RE, 0, "R6");
    idle(25);
    // R6 passed value does not fire
    rd_tick();
    wr(S_CMPS, t - 64'd3);
    push(n0 + 30, K_SI, 0, "R6");
    idle(32);
    wr(S_CMPS, DIS); idle(2);
    // R8 hypervisor match
    rd_tick();
    wr(S_CMPH, t + 64'd20);
    push(n0 + 20, K_HY, 0, "R8");
    push(n0 + 21, K_HY, 1, "R8"); push(n0 + 21, K_RE, 1, "R8");
    push(n0 + 26, K_HY, 1, "R8"); push(n0 + 26, K_SI, 0, "R8");
    idle(27);
    wr(S_CMPH, DIS); ex(1, K_HY, 0, "R8");
    // R9 interrupt level
    wr(S_PIL, 64'd5); ex(1, K_RE, 0, "R9");
    wr(S_PIL, 64'd2); ex(1, K_RE, 1, "R9");
    wr(S_PIL, 64'd2); ex(1, K_RE, 0, "R9");
    rd(S_PIL, 64'd2, "R9");
    // R10 enable rise
    wr(S_STATE, 64'h02); ex(1, K_RE, 1, "R10");
    wr(S_STATE, 64'h03); ex(1, K_RE, 0, "R10");
    wr(S_STATE, 64'h00); ex(1, K_RE, 0, "R10");
    rd(S_STATE, 64'h00, "R10");
    // R11 trap base
    wr(S_TBA, '1); rd(S_TBA, ~64'h7FFF, "R11");
    // R12 version
    rd(S_VER, 64'h03_06_08, "R12");
    wr(S_VER, 64'hDEAD); ex(1, K_ER, 1, "R12");
    rd(S_VER, 64'h03_06_08, "R12"); ex(1, K_ER, 0, "R12");
    wr(4'd12, 64'h55); ex(1, K_ER, 1, "R12"); ex(1, K_SI, 0, "R12");
    wr(S_SOFT, 64'h1); ex(1, K_ER, 0, "R12");
    idle(4);
    if (q.size() != 0) begin
      n_fail++;
      $display("FAIL queue: actual %0d left expected 0", q.size());
    end
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule